// File: doc/BRIEF.md
# Pipelined Signed Complex Multiplier with Column-Serial Product Cores

This block forms the product of two complex numbers, (ar + j·ai) × (br + j·bi). Each of the four operand parts is a signed two's-complement word of `W` bits. The block returns the real part ar·br − ai·bi and the imaginary part ar·bi + ai·br. Each is an exact signed word of 2W+1 bits, so the final subtraction or addition never wraps.

Each of the four real products is built column by column, starting at the least significant bit. Column k adds up every bit product a[i]·b[j] with i + j = k, together with the carry word handed on from column k−1. The carry into column 0 is zero. The lowest bit of that column sum becomes product bit k, and the remaining upper bits become the carry into the next column.

Signs are handled outside the column core:
- the core multiplies the unsigned magnitudes of the two operands;
- the product is negated when exactly one operand is negative.

The interface has no handshake. Operands are captured on any clock edge where `in_valid` is high. The result appears with `out_valid` exactly three clock edges later, and a new operand set may be accepted on every cycle.

Top module: `cvx_cmul`

## Requirements
- R1: When `out_valid` is high, `out_re` equals ar·br − ai·bi for the operand set accepted three edges earlier, as an exact signed (2W+1)-bit value.
- R2: When `out_valid` is high, `out_im` equals ar·bi + ai·br for that same operand set, as an exact signed (2W+1)-bit value.
- R3: `out_valid` equals `in_valid` delayed by exactly three rising clock edges; the data belonging to an accepted set appear in the same cycle as its `out_valid`.
- R4: `rst` is synchronous and active high; every in-flight valid bit is cleared, so `out_valid` is low in the cycle after any edge with `rst` high, including when operands were in flight.
- R5: The most negative operand value −2^(W−1) yields an exact product; for W=8, ar=br=−128 with ai=bi=0 gives `out_re`=16384 and `out_im`=0.
- R6: Operands are two's complement with the MSB as sign; a product is negative exactly when the two factors' signs differ (±1 and all-ones patterns give ±1 products).
- R7: Operand sets presented on consecutive cycles each produce their own correct result on consecutive cycles, with no interaction.
- R8: A cycle with `in_valid` low produces no result: `out_valid` is low three edges later, whatever the operand inputs carried.
- R9: The imaginary output holds its extreme value without overflow; for W=8, all four parts −128 gives `out_im`=+32768 and `out_re`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand set present; captured at this edge |
| ar | input | W | Real part of first operand, signed |
| ai | input | W | Imaginary part of first operand, signed |
| br | input | W | Real part of second operand, signed |
| bi | input | W | Imaginary part of second operand, signed |
| out_valid | output | 1 | Result present, three edges after acceptance |
| out_re | output | 2W+1 | Real part of product, signed |
| out_im | output | 2W+1 | Imaginary part of product, signed |

## Verification
The bench targets the most negative operand. A magnitude path one bit too narrow would wrap −128 back to −128 and return a product of the wrong sign or size. It also targets the all-minus-128 case, where an output only 2W bits wide would show +32768 as a negative number. Mixed-sign and ±1 operands check the sign correction: a wrong sign XOR or a missing +1 in the negation shows up as an off-by-one or sign-flipped result. A reset while operands are in flight, and gaps in `in_valid` carrying junk data, check that valid bits are cleared and never invented.

// File: rtl/cvx_cmul.sv
module cvx_cmul #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [W-1:0]   ar,
  input  logic signed [W-1:0]   ai,
  input  logic signed [W-1:0]   br,
  input  logic signed [W-1:0]   bi,
  output logic                  out_valid,
  output logic signed [2*W:0]   out_re,
  output logic signed [2*W:0]   out_im
);
  localparam int PW = 2 * W;
  localparam int CW = 2 * W;

  function automatic logic [PW-1:0] col_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [CW-1:0] acc;
    logic [PW-1:0] p;
    acc = '0;
    p   = '0;
    for (int k = 0; k < PW - 1; k++) begin
      for (int i = 0; i < W; i++) begin
        if (k - i >= 0 && k - i < W)
          acc = acc + CW'(a[i] & b[k-i]);
      end
      p[k] = acc[0];
      acc  = acc >> 1;
    end
    p[PW-1] = acc[0];
    return p;
  endfunction

  logic signed [W-1:0] ar_q, ai_q, br_q, bi_q;
  logic                v1, v2, v3;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      ar_q <= ar;
      ai_q <= ai;
      br_q <= br;
      bi_q <= bi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  logic [W-1:0]  xa [4];
  logic [W-1:0]  xb [4];
  logic [PW-1:0] prod [4];

  assign xa[0] = ar_q;  assign xb[0] = br_q;
  assign xa[1] = ai_q;  assign xb[1] = bi_q;
  assign xa[2] = ar_q;  assign xb[2] = bi_q;
  assign xa[3] = ai_q;  assign xb[3] = br_q;

  for (genvar g = 0; g < 4; g++) begin : g_mul
    logic          neg;
    logic [W-1:0]  ma, mb;
    logic [PW-1:0] um, sm;
    assign neg = xa[g][W-1] ^ xb[g][W-1];
    assign ma  = xa[g][W-1] ? (~xa[g] + W'(1)) : xa[g];
    assign mb  = xb[g][W-1] ? (~xb[g] + W'(1)) : xb[g];
    assign um  = col_mul(ma, mb);
    assign sm  = neg ? (~um + PW'(1)) : um;
    always_ff @(posedge clk) begin
      if (v1) prod[g] <= sm;
    end
  end

  always_ff @(posedge clk) begin
    if (v2) begin
      out_re <= $signed({prod[0][PW-1], prod[0]}) - $signed({prod[1][PW-1], prod[1]});
      out_im <= $signed({prod[2][PW-1], prod[2]}) + $signed({prod[3][PW-1], prod[3]});
    end
  end

  assign out_valid = v3;
endmodule

// File: rtl/cvx_cmul_chk.sv
module cvx_cmul_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic signed [W-1:0] ar,
  input logic signed [W-1:0] ai,
  input logic signed [W-1:0] br,
  input logic signed [W-1:0] bi,
  input logic                out_valid,
  input logic signed [2*W:0] out_re,
  input logic signed [2*W:0] out_im
);
  localparam int OW = 2 * W + 1;
  localparam logic signed [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [OW-1:0] MINSQ = OW'(1) << (2 * W - 2);

  logic signed [OW-1:0] ref_re, ref_im;
  logic [1:0] warm;

  assign ref_re = OW'(ar) * OW'(br) - OW'(ai) * OW'(bi);
  assign ref_im = OW'(ar) * OW'(bi) + OW'(ai) * OW'(br);

  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_real_r1: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid) |-> (out_re == $past(ref_re, 3)));

  p_imag_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid) |-> (out_im == $past(ref_im, 3)));

  p_reset_r4: assert property (@(posedge clk)
    rst |=> !out_valid);

  p_minneg_r5: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid && $past(ar, 3) == MINV && $past(br, 3) == MINV &&
     $past(ai, 3) == '0 && $past(bi, 3) == '0) |-> (out_re == MINSQ && out_im == '0));
endmodule

bind cvx_cmul cvx_cmul_chk #(.W(W)) i_chk (.*);

// File: tb/test_cvx_cmul.sv
module test_cvx_cmul;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] ar = '0, ai = '0, br = '0, bi = '0;
  logic out_valid;
  logic signed [2*W:0] out_re, out_im;

  int compared = 0;
  int mismatched = 0;
  string phase = "R4";
  bit running = 1'b0;

  longint mre [3];
  longint mim [3];
  bit     mv  [3];

  cvx_cmul #(.W(W)) i_cvx_cmul (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .ar(ar), .ai(ai), .br(br), .bi(bi),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    longint a_r, a_i, b_r, b_i;
    a_r = longint'(ar); a_i = longint'(ai); b_r = longint'(br); b_i = longint'(bi);
    mre[2] <= mre[1]; mre[1] <= mre[0]; mre[0] <= a_r * b_r - a_i * b_i;
    mim[2] <= mim[1]; mim[1] <= mim[0]; mim[0] <= a_r * b_i + a_i * b_r;
    if (rst) begin
      mv[0] <= 1'b0; mv[1] <= 1'b0; mv[2] <= 1'b0;
    end else begin
      mv[2] <= mv[1]; mv[1] <= mv[0]; mv[0] <= in_valid;
    end
  end

  task automatic check(string req, bit ok, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check("R3", out_valid === mv[2], longint'(out_valid), longint'(mv[2]));
      if (mv[2]) begin
        check("R1", out_re === (2*W+1)'(mre[2]), longint'(out_re), mre[2]);
        check("R2", out_im === (2*W+1)'(mim[2]), longint'(out_im), mim[2]);
      end
    end
  end

  task automatic put(bit v, int a_r, int a_i, int b_r, int b_i);
    @(negedge clk);
    #1;
    in_valid = v;
    ar = W'(a_r); ai = W'(a_i); br = W'(b_r); bi = W'(b_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(1'b0, $urandom, $urandom, $urandom, $urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R3 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    running = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    idle(4);

    phase = "R1";
    put(1, 0, 0, 0, 0);
    put(1, 3, 5, 7, 2);
    put(1, 0, 0, 55, -17);

    phase = "R6";
    put(1, 1, 0, 1, 0);
    put(1, -1, 0, 1, 0);
    put(1, 1, -1, -1, 1);
    put(1, -1, -1, -1, -1);
    put(1, 0, 1, 0, 1);

    phase = "R5";
    put(1, -128, 0, -128, 0);
    put(1, -128, 0, 127, 0);
    put(1, 0, -128, 0, 1);
    put(1, -128, -128, 127, -128);

    phase = "R9";
    put(1, -128, -128, -128, -128);
    put(1, 127, 127, 127, 127);
    put(1, 127, -128, -128, 127);
    idle(4);

    phase = "R8";
    for (int i = 0; i < 6; i++) begin
      put(1, i, -i, 2 * i, 3);
      put(0, -128, -128, -128, -128);
      put(0, 99, 99, 99, 99);
    end
    idle(4);

    phase = "R4";
    put(1, 10, 20, 30, 40);
    put(1, -10, 20, -30, 40);
    put(1, 50, 60, 70, 80);
    @(negedge clk); #1 rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); #1 rst = 1'b0;
    idle(5);

    phase = "R7";
    for (int i = 0; i < 2000; i++)
      put(($urandom % 5) != 0, $urandom, $urandom, $urandom, $urandom);
    idle(5);

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule